// File: doc/BRIEF.md
# Gated Memory Array Line Sequencer

This controller drives the row and column lines of a non-volatile memory array whose three-terminal cells are selected through their own gate instead of an access transistor. It accepts one request at a time (read, write, hold or sleep) with a row address and a data word. It steps each access through a setup, an assert and a restore phase. For every word line, bit line, bit-line-bar, sense line and sense-line-bar it emits a two-bit symbolic drive code. Analog levels, the storage physics and the sense amplifier are outside the block.

The cells turn on with a low gate, so only the selected row's word line goes low, and only while the access is asserted. The polarity of a write comes from which of the two data lines of a column is low. During a write the sense lines stay precharged and floating, so that no current can disturb the cell. A read raises both data lines and pulls the sense lines to a read-bias level. Each column has a differential cell, so its per-column comparator result is the bit itself and needs no reference. When an access ends, every line returns to the high precharge level. Sleep pulls every line low, and leaving sleep always costs one full restore phase before any access begins.

Top module: `mem_line_seq`

## Requirements
- R1: After reset every line carries the high code, `req_ready` is 1, `done` is 0 and `rd_data` is 0. The line codes are low=0, high=1, float-high=2 and read-bias=3, and line n occupies bits [2n+1:2n] of its bus.
- R2: In the setup and assert phases of a write, a data bit of 0 drives its bit line low and its bit-line-bar high. A data bit of 1 drives the bit line high and the bit-line-bar low.
- R3: In the setup and assert phases of a write, every sense line and every sense-line-bar carries float-high.
- R4: In the setup and assert phases of a read, every bit line and bit-line-bar is high and every sense line and sense-line-bar carries read-bias.
- R5: Only the addressed word line goes low, and only during the assert phase. All other word lines stay high.
- R6: An access spends one cycle in setup. It then spends max(`assert_cycles`,1) cycles in assert and `RESTORE_CYC` cycles in restore, with all lines high during restore. A hold request performs only the restore phase.
- R7: A request is taken only when `req_ready` is 1, which happens only in the idle and sleep states. Requests presented while busy have no effect. The op codes are read=0, write=1, hold=2 and sleep=3. `done` pulses for exactly one cycle, in the first cycle after the last restore cycle.
- R8: A sleep request drives every line low from the next cycle on, and `done` pulses in that same cycle.
- R9: A read, write or hold request taken in sleep first spends `RESTORE_CYC` cycles with all lines high. After that, a read or write goes on to its setup phase, and a hold completes.
- R10: `rd_data` takes the value of `sense_cmp` sampled in the last assert cycle of a read. A 1 means the complement-side current was larger, which means a stored 1. The value holds unchanged until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | Operation: read=0, write=1, hold=2, sleep=3 |
| req_addr | input | ADDR_W | Row (word) address |
| req_wdata | input | WORD_W | Write data |
| assert_cycles | input | CNT_W | Assert phase length (0 treated as 1) |
| sense_cmp | input | WORD_W | Per-column comparator result |
| req_ready | output | 1 | Sequencer idle or asleep, request accepted |
| done | output | 1 | One-cycle completion strobe |
| rd_data | output | WORD_W | Last word read |
| wl_drv | output | 2*ROWS | Word line drive codes |
| bl_drv | output | 2*WORD_W | Bit line drive codes |
| blb_drv | output | 2*WORD_W | Bit-line-bar drive codes |
| sl_drv | output | 2*WORD_W | Sense line drive codes |
| slb_drv | output | 2*WORD_W | Sense-line-bar drive codes |

## Verification
Some properties are checked on every cycle. At most one word line is low, and one can be low only in the assert phase. Each data-line pair is complementary during a write, the sense lines float during a write, and read bias appears during a read. Restore drives every line high and sleep drives every line low. Ready is only raised in the idle and sleep states, done never lasts two cycles, and the read word changes only at its capture point. The bench scenarios are needed for the quantities that depend on timing. These are the exact number of setup, assert and restore cycles for each `assert_cycles` value, including the zero case, and the extra restore phase on wake from sleep. The scenarios also show that only the comparator value of the last assert cycle is kept, and that requests presented while the sequencer is busy leave the line sequence untouched.

// File: rtl/mls_pkg.sv
package mls_pkg;

  typedef enum logic [1:0] {
    DRV_LOW     = 2'd0,
    DRV_HIGH    = 2'd1,
    DRV_FLOATHI = 2'd2,
    DRV_RBIAS   = 2'd3
  } drv_e;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_HOLD  = 2'd2,
    OP_SLEEP = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_SLEEP   = 3'd1,
    PH_SETUP   = 3'd2,
    PH_ASSERT  = 3'd3,
    PH_RESTORE = 3'd4
  } phase_e;

  function automatic logic is_access(op_e op);
    return (op == OP_READ) || (op == OP_WRITE);
  endfunction

  function automatic logic drives_data(phase_e ph);
    return (ph == PH_SETUP) || (ph == PH_ASSERT);
  endfunction

  // Assert length: a zero request still yields one cycle.
  function automatic logic [15:0] assert_len(logic [15:0] req);
    return (req == 16'd0) ? 16'd1 : req;
  endfunction

  // bar=0 selects the true line of the pair, bar=1 the complement line.
  function automatic drv_e data_line_code(phase_e ph, op_e op, logic bitv, logic bar);
    drv_e c;
    if (ph == PH_SLEEP) c = DRV_LOW;
    else if (drives_data(ph) && op == OP_WRITE) c = (bitv ^ bar) ? DRV_HIGH : DRV_LOW;
    else c = DRV_HIGH;
    return c;
  endfunction

  function automatic drv_e sense_line_code(phase_e ph, op_e op);
    drv_e c;
    if (ph == PH_SLEEP) c = DRV_LOW;
    else if (drives_data(ph) && op == OP_WRITE) c = DRV_FLOATHI;
    else if (drives_data(ph) && op == OP_READ) c = DRV_RBIAS;
    else c = DRV_HIGH;
    return c;
  endfunction

  function automatic drv_e word_line_code(phase_e ph, logic sel);
    drv_e c;
    if (ph == PH_SLEEP) c = DRV_LOW;
    else if (ph == PH_ASSERT && sel) c = DRV_LOW;
    else c = DRV_HIGH;
    return c;
  endfunction

endpackage

// File: rtl/mls_phase_ctrl.sv
module mls_phase_ctrl
  import mls_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int WORD_W      = 32,
  parameter int CNT_W       = 4,
  parameter int RESTORE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  op_e               req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic [CNT_W-1:0]  assert_cycles,
  output phase_e            phase,
  output op_e               cur_op,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [WORD_W-1:0] cur_data,
  output logic              req_ready,
  output logic              done,
  output logic              cap_en
);

  localparam int RW = $clog2(RESTORE_CYC + 1);
  localparam int CW = (CNT_W > RW) ? CNT_W : RW;

  phase_e            phase_q;
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] data_q;
  logic [CW-1:0]     cnt_q;
  logic [CW-1:0]     len_q;
  logic              wake_q;
  logic              done_q;

  logic assert_last;
  logic restore_last;

  assign assert_last  = (phase_q == PH_ASSERT)  && (cnt_q == len_q - CW'(1));
  assign restore_last = (phase_q == PH_RESTORE) && (cnt_q == CW'(RESTORE_CYC - 1));
  assign req_ready    = (phase_q == PH_IDLE) || (phase_q == PH_SLEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      op_q    <= OP_HOLD;
      addr_q  <= '0;
      data_q  <= '0;
      cnt_q   <= '0;
      len_q   <= CW'(1);
      wake_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        PH_IDLE, PH_SLEEP: begin
          if (req_valid) begin
            op_q   <= req_op;
            addr_q <= req_addr;
            data_q <= req_wdata;
            len_q  <= CW'(assert_len(16'(assert_cycles)));
            cnt_q  <= '0;
            if (req_op == OP_SLEEP) begin
              phase_q <= PH_SLEEP;
              wake_q  <= 1'b0;
              done_q  <= 1'b1;
            end else if (phase_q == PH_SLEEP) begin
              phase_q <= PH_RESTORE;
              wake_q  <= 1'b1;
            end else if (req_op == OP_HOLD) begin
              phase_q <= PH_RESTORE;
              wake_q  <= 1'b0;
            end else begin
              phase_q <= PH_SETUP;
              wake_q  <= 1'b0;
            end
          end
        end
        PH_SETUP: begin
          phase_q <= PH_ASSERT;
          cnt_q   <= '0;
        end
        PH_ASSERT: begin
          if (assert_last) begin
            phase_q <= PH_RESTORE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        PH_RESTORE: begin
          if (restore_last) begin
            cnt_q  <= '0;
            wake_q <= 1'b0;
            if (wake_q && is_access(op_q)) begin
              phase_q <= PH_SETUP;
            end else begin
              phase_q <= PH_IDLE;
              done_q  <= 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase    = phase_q;
  assign cur_op   = op_q;
  assign cur_addr = addr_q;
  assign cur_data = data_q;
  assign done     = done_q;
  assign cap_en   = assert_last && (op_q == OP_READ);

endmodule

// File: rtl/mls_line_drv.sv
module mls_line_drv
  import mls_pkg::*;
#(
  parameter int ROWS   = 1024,
  parameter int ADDR_W = 10,
  parameter int WORD_W = 32
) (
  input  phase_e              phase,
  input  op_e                 op,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [WORD_W-1:0]   data,
  output logic [2*ROWS-1:0]   wl_drv,
  output logic [2*WORD_W-1:0] bl_drv,
  output logic [2*WORD_W-1:0] blb_drv,
  output logic [2*WORD_W-1:0] sl_drv,
  output logic [2*WORD_W-1:0] slb_drv
);

  drv_e sense_code;
  assign sense_code = sense_line_code(phase, op);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign wl_drv[2*r +: 2] = word_line_code(phase, addr == ADDR_W'(r));
  end

  for (genvar c = 0; c < WORD_W; c++) begin : g_col
    assign bl_drv[2*c +: 2]  = data_line_code(phase, op, data[c], 1'b0);
    assign blb_drv[2*c +: 2] = data_line_code(phase, op, data[c], 1'b1);
    assign sl_drv[2*c +: 2]  = sense_code;
    assign slb_drv[2*c +: 2] = sense_code;
  end

endmodule

// File: rtl/mls_sense_cap.sv
module mls_sense_cap #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [WORD_W-1:0] sense_cmp,
  output logic [WORD_W-1:0] rd_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else if (cap_en) rd_data <= sense_cmp;
  end

endmodule

// File: rtl/mem_line_seq.sv
module mem_line_seq
  import mls_pkg::*;
#(
  parameter int ROWS        = 1024,
  parameter int WORD_W      = 32,
  parameter int CNT_W       = 4,
  parameter int RESTORE_CYC = 2,
  parameter int ADDR_W      = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [1:0]          req_op,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [WORD_W-1:0]   req_wdata,
  input  logic [CNT_W-1:0]    assert_cycles,
  input  logic [WORD_W-1:0]   sense_cmp,
  output logic                req_ready,
  output logic                done,
  output logic [WORD_W-1:0]   rd_data,
  output logic [2*ROWS-1:0]   wl_drv,
  output logic [2*WORD_W-1:0] bl_drv,
  output logic [2*WORD_W-1:0] blb_drv,
  output logic [2*WORD_W-1:0] sl_drv,
  output logic [2*WORD_W-1:0] slb_drv
);

  phase_e            phase_w;
  op_e               op_w;
  logic [ADDR_W-1:0] addr_w;
  logic [WORD_W-1:0] data_w;
  logic              cap_en_w;

  mls_phase_ctrl #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .CNT_W(CNT_W), .RESTORE_CYC(RESTORE_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(op_e'(req_op)),
    .req_addr(req_addr), .req_wdata(req_wdata), .assert_cycles(assert_cycles),
    .phase(phase_w), .cur_op(op_w), .cur_addr(addr_w), .cur_data(data_w),
    .req_ready(req_ready), .done(done), .cap_en(cap_en_w)
  );

  mls_line_drv #(
    .ROWS(ROWS), .ADDR_W(ADDR_W), .WORD_W(WORD_W)
  ) u_drv (
    .phase(phase_w), .op(op_w), .addr(addr_w), .data(data_w),
    .wl_drv(wl_drv), .bl_drv(bl_drv), .blb_drv(blb_drv),
    .sl_drv(sl_drv), .slb_drv(slb_drv)
  );

  mls_sense_cap #(
    .WORD_W(WORD_W)
  ) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en_w), .sense_cmp(sense_cmp), .rd_data(rd_data)
  );

endmodule

// File: rtl/mls_seq_chk.sv
module mls_seq_chk
  import mls_pkg::*;
#(
  parameter int ROWS   = 1024,
  parameter int WORD_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input phase_e              phase,
  input op_e                 op,
  input logic                cap_en,
  input logic                req_ready,
  input logic                done,
  input logic [WORD_W-1:0]   rd_data,
  input logic [2*ROWS-1:0]   wl_drv,
  input logic [2*WORD_W-1:0] bl_drv,
  input logic [2*WORD_W-1:0] blb_drv,
  input logic [2*WORD_W-1:0] sl_drv,
  input logic [2*WORD_W-1:0] slb_drv
);

  localparam logic [2*ROWS-1:0]   WL_HI  = {ROWS{2'b01}};
  localparam logic [2*WORD_W-1:0] COL_HI = {WORD_W{2'b01}};
  localparam logic [2*WORD_W-1:0] COL_FL = {WORD_W{2'b10}};
  localparam logic [2*WORD_W-1:0] COL_RB = {WORD_W{2'b11}};

  logic [ROWS-1:0] wl_low;
  always_comb begin
    for (int r = 0; r < ROWS; r++) wl_low[r] = (wl_drv[2*r +: 2] == 2'b00);
  end

  logic in_data_ph;
  assign in_data_ph = (phase == PH_SETUP) || (phase == PH_ASSERT);

  AST_ONE_WL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_SLEEP) |-> ($countones(wl_low) <= 1)); // R5
  AST_WL_LOW_ONLY_ASSERT: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase != PH_SLEEP) && (wl_low != '0)) |-> (phase == PH_ASSERT)); // R5
  AST_WR_PAIR_OPPOSITE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data_ph && op == OP_WRITE) |-> ((bl_drv ^ blb_drv) == COL_HI)); // R2
  AST_WR_SENSE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data_ph && op == OP_WRITE) |-> (sl_drv == COL_FL && slb_drv == COL_FL)); // R3
  AST_RD_BIAS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data_ph && op == OP_READ) |-> (sl_drv == COL_RB && slb_drv == COL_RB
                                       && bl_drv == COL_HI && blb_drv == COL_HI)); // R4
  AST_RESTORE_ALL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RESTORE) |-> (wl_drv == WL_HI && bl_drv == COL_HI && blb_drv == COL_HI
                               && sl_drv == COL_HI && slb_drv == COL_HI)); // R6
  AST_SLEEP_ALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SLEEP) |-> (wl_drv == '0 && bl_drv == '0 && blb_drv == '0
                             && sl_drv == '0 && slb_drv == '0)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_READY_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (phase == PH_IDLE || phase == PH_SLEEP)); // R7
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(rd_data)); // R10

endmodule

bind mem_line_seq mls_seq_chk #(.ROWS(ROWS), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase_w), .op(op_w), .cap_en(cap_en_w),
  .req_ready(req_ready), .done(done), .rd_data(rd_data), .wl_drv(wl_drv),
  .bl_drv(bl_drv), .blb_drv(blb_drv), .sl_drv(sl_drv), .slb_drv(slb_drv)
);

// File: tb/mem_line_seq_tb.sv
`timescale 1ns/1ps
module mem_line_seq_tb;

  localparam int ROWS = 4;
  localparam int W    = 4;
  localparam int CW   = 3;
  localparam int RC   = 2;
  localparam int AW   = 2;

  localparam logic [1:0] L = 2'd0, H = 2'd1, F = 2'd2, B = 2'd3;
  localparam int OPR = 0, OPW = 1, OPH = 2, OPS = 3;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0;
  logic [1:0] req_op = 0;
  logic [AW-1:0] req_addr = 0;
  logic [W-1:0] req_wdata = 0;
  logic [CW-1:0] assert_cycles = 0;
  logic [W-1:0] sense_cmp = 0;
  logic req_ready, done;
  logic [W-1:0] rd_data;
  logic [2*ROWS-1:0] wl_drv;
  logic [2*W-1:0] bl_drv, blb_drv, sl_drv, slb_drv;

  int total_n = 0;
  int bad_n = 0;
  int cyc = 0;
  logic in_sleep = 0;
  logic [W-1:0] rd_exp = 0;

  always #2 clk = ~clk;

  mem_line_seq #(.ROWS(ROWS), .WORD_W(W), .CNT_W(CW), .RESTORE_CYC(RC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .assert_cycles(assert_cycles),
    .sense_cmp(sense_cmp), .req_ready(req_ready), .done(done), .rd_data(rd_data),
    .wl_drv(wl_drv), .bl_drv(bl_drv), .blb_drv(blb_drv), .sl_drv(sl_drv), .slb_drv(slb_drv)
  );

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total_n, bad_n);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad_n = bad_n + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total_n++;
    if (!ok) begin
      bad_n++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ph: 0 = all high (idle/restore), 1 = sleep, 2 = setup, 3 = assert
  task automatic exp_lines(input int ph, input int op, input int addr, input logic [W-1:0] d,
                           output logic [2*ROWS-1:0] wl, output logic [2*W-1:0] bl,
                           output logic [2*W-1:0] blb, output logic [2*W-1:0] sl,
                           output logic [2*W-1:0] slb);
    for (int r = 0; r < ROWS; r++)
      wl[2*r +: 2] = (ph == 1 || (ph == 3 && r == addr)) ? L : H;
    for (int i = 0; i < W; i++) begin
      if (ph == 1) begin
        bl[2*i +: 2] = L; blb[2*i +: 2] = L; sl[2*i +: 2] = L; slb[2*i +: 2] = L;
      end else if (ph >= 2 && op == OPW) begin
        bl[2*i +: 2] = d[i] ? H : L; blb[2*i +: 2] = d[i] ? L : H;
        sl[2*i +: 2] = F; slb[2*i +: 2] = F;
      end else if (ph >= 2 && op == OPR) begin
        bl[2*i +: 2] = H; blb[2*i +: 2] = H; sl[2*i +: 2] = B; slb[2*i +: 2] = B;
      end else begin
        bl[2*i +: 2] = H; blb[2*i +: 2] = H; sl[2*i +: 2] = H; slb[2*i +: 2] = H;
      end
    end
  endtask

  task automatic check_lines(input int ph, input int op, input int addr, input logic [W-1:0] d,
                             input string tag);
    logic [2*ROWS-1:0] ewl;
    logic [2*W-1:0] ebl, eblb, esl, eslb;
    exp_lines(ph, op, addr, d, ewl, ebl, eblb, esl, eslb);
    chk(wl_drv == ewl, {tag, " word lines"}, 64'(wl_drv), 64'(ewl));
    chk({bl_drv, blb_drv} == {ebl, eblb}, {tag, " data lines"},
        64'({bl_drv, blb_drv}), 64'({ebl, eblb}));
    chk({sl_drv, slb_drv} == {esl, eslb}, {tag, " sense lines"},
        64'({sl_drv, slb_drv}), 64'({esl, eslb}));
  endtask

  task automatic run_op(input int op, input int addr, input logic [W-1:0] d,
                        input int acyc, input logic [W-1:0] pat);
    int a_len, base, total, ph;
    bit acc, rdy;
    string tag;
    a_len = (acyc == 0) ? 1 : acyc;
    base  = (in_sleep && op != OPS) ? RC : 0;
    acc   = (op == OPR) || (op == OPW);
    if (op == OPS) total = 1;
    else if (op == OPH) total = RC + 1;
    else total = base + 2 + a_len + RC;
    @(negedge clk);
    req_valid = 1; req_op = 2'(op); req_addr = AW'(addr); req_wdata = d;
    assert_cycles = CW'(acyc);
    for (int k = 1; k <= total; k++) begin
      @(negedge clk);
      rdy = 0;
      if (op == OPS) begin ph = 1; rdy = 1; end
      else if (k == total) begin ph = 0; rdy = 1; end
      else if (acc && k == base + 1) ph = 2;
      else if (acc && k >= base + 2 && k <= base + 1 + a_len) ph = 3;
      else ph = 0;
      if (ph == 1) tag = "R8";
      else if (ph >= 2 && op == OPW) tag = "R2 R3 R5";
      else if (ph >= 2) tag = "R4 R5";
      else if (k <= base) tag = "R9";
      else tag = "R6";
      check_lines(ph, op, addr, d, tag);
      chk(done == (k == total), "R7 done", 64'(done), 64'(k == total));
      chk(req_ready == rdy, "R7 ready", 64'(req_ready), 64'(rdy));
      if (k < total) begin
        req_valid = 1; req_op = 2'(OPS); req_addr = AW'(addr + 1); req_wdata = ~d;
        assert_cycles = CW'(acyc + 3);
      end else begin
        req_valid = 0;
      end
      sense_cmp = (op == OPR && k == base + 1 + a_len) ? pat : ~pat;
    end
    if (op == OPR) rd_exp = pat;
    chk(rd_data == rd_exp, "R10 read word", 64'(rd_data), 64'(rd_exp));
    in_sleep = (op == OPS);
  endtask

  initial begin
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_lines(0, OPH, 0, '0, "R1");
    chk(req_ready == 1'b1, "R1 ready", 64'(req_ready), 64'd1);
    chk(done == 1'b0, "R1 done", 64'(done), 64'd0);
    chk(rd_data == '0, "R1 rd_data", 64'(rd_data), 64'd0);

    // R2 R5 R6: every row, every data word, assert lengths 0..7
    for (int r = 0; r < ROWS; r++)
      for (int d = 0; d < (1 << W); d++)
        run_op(OPW, r, W'(d), (r + d) % 8, W'(d ^ 5));

    // R4 R10: reads with varying patterns and lengths
    for (int r = 0; r < ROWS; r++)
      for (int p = 0; p < (1 << W); p += 3)
        run_op(OPR, r, W'(p), (p + r) % 4, W'(p ^ r));

    run_op(OPH, 0, '0, 0, '0);
    run_op(OPS, 0, '0, 0, '0);
    run_op(OPR, 2, '0, 2, 4'b1011);             // R9 wake into read
    run_op(OPS, 0, '0, 0, '0);
    run_op(OPW, 3, 4'b0110, 1, 4'b0001);        // R9 wake into write
    run_op(OPS, 0, '0, 0, '0);
    run_op(OPS, 0, '0, 0, '0);                  // R8 sleep while asleep
    run_op(OPH, 1, '0, 0, '0);                  // R9 wake with hold
    run_op(OPW, 1, 4'b1111, 7, 4'b0000);
    run_op(OPR, 0, '0, 0, 4'b0110);

    summary();
    $finish;
  end

endmodule